// File: doc/BRIEF.md
# Two-Stage Clock Prescaler

This block derives a slow event rate from a fast clock without creating a new clock domain. A linear divider counts 0..M and wraps. Each of its wraps advances a binary stage that counts 2^(N+1) steps. The block therefore produces one enable pulse every 2^(N+1) × (M+1) input clocks. The total ratio is always even, and the smallest possible ratio is 2.

Next to the single-cycle enable, the block drives a square wave with 50 % duty at the same divided rate, for logic that needs a level rather than a strobe. Software-side logic loads a 32-bit setting word with a one-cycle load strobe. The block holds the new setting until the running output period ends, so that no shortened period is ever produced.

Top module: `clk_presc`

## Requirements
- R1: While `rst` is high, `tick` and `half_clk` are 0. Reset clears both stage counters and selects the default setting N=1, M=9, so the first period after reset lasts 40 clocks.
- R2: `tick` is high for exactly one clock per period. The cycle after reset release counts as cycle 0 of a period, and the period lasts 2^(N+1) × (M+1) clocks, with `tick` high in its last cycle.
- R3: The linear field M is `cfg_word[11:0]` and the exponent field N is `cfg_word[15:12]`. For example, 32'h0000_3018 gives a period of 16 × 25 = 400 clocks.
- R4: Bits `cfg_word[31:16]` are ignored. 32'hABCD_1005 gives the same 24-clock period as 32'h0000_1005.
- R5: `half_clk` is 0 during the first 2^N × (M+1) clocks of each period and 1 during the remaining 2^N × (M+1) clocks.
- R6: A load during a period does not change that period. The new setting applies from the next period on.
- R7: A load in the same cycle that `tick` is high applies to the period that starts right after that cycle.
- R8: When several loads fall within one period, the last one sets the next period.
- R9: N=0, M=0 gives `tick` on every second clock, and `half_clk` toggles on every clock.
- R10: The fields take their full range. Settings N=6/M=124 (16000 clocks), N=4/M=399 (12800 clocks) and N=0/M=2593 (5188 clocks) each produce their exact ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that captures `cfg_word` |
| cfg_word | input | 32 | Setting word: M in [11:0], N in [15:12] |
| tick | output | 1 | One-clock enable pulse at the end of each divided period |
| half_clk | output | 1 | 50 % duty square wave at the divided rate |

## Verification
The assertions check the invariants that hold on every cycle:
- the linear count never passes its limit;
- the active setting changes only at a period boundary;
- `half_clk` changes only after a linear wrap;
- `tick` is never high on two cycles in a row and is always followed by a low `half_clk`.

Only the bench scenarios can show the exact period lengths and half-period split for each setting, the field positions and ignored upper bits, and the timing of a setting change. That timing covers a load at the boundary, a load in mid-period, and several loads in one period.

// File: rtl/clk_presc_pkg.sv
package clk_presc_pkg;

    localparam int LIN_W   = 12;
    localparam int EXP_W   = 4;
    localparam int EXP_LSB = 12;
    localparam int WORD_W  = 32;
    localparam int BIN_W   = 1 << EXP_W;

    localparam int DEF_EXP = 1;
    localparam int DEF_LIN = 9;

    typedef struct packed {
        logic [EXP_W-1:0] expo;
        logic [LIN_W-1:0] lin;
    } presc_cfg_t;

    localparam presc_cfg_t DEF_CFG = '{expo: EXP_W'(DEF_EXP), lin: LIN_W'(DEF_LIN)};

    function automatic presc_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        presc_cfg_t c;
        c.lin  = w[LIN_W-1:0];
        c.expo = w[EXP_LSB +: EXP_W];
        return c;
    endfunction

    function automatic logic [BIN_W-1:0] bin_limit(input logic [EXP_W-1:0] e);
        return {BIN_W{1'b1}} >> (BIN_W - 1 - int'(e));
    endfunction

endpackage

// File: rtl/presc_cfg_hold.sv
module presc_cfg_hold
    import clk_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              boundary,
    output presc_cfg_t        active
);
    presc_cfg_t pending;
    presc_cfg_t incoming;

    assign incoming = unpack_cfg(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= DEF_CFG;
            active  <= DEF_CFG;
        end else begin
            if (load)
                pending <= incoming;
            if (boundary)
                active <= load ? incoming : pending;
        end
    end

    // R6
    cfg_swap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> $past(boundary));

endmodule

// File: rtl/presc_lin_stage.sv
module presc_lin_stage
    import clk_presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LIN_W-1:0] lim,
    output logic             wrap
);
    logic [LIN_W-1:0] cnt;

    assign wrap = (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2
    lin_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);

    // R2
    lin_restart_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt == '0);

endmodule

// File: rtl/presc_bin_stage.sv
module presc_bin_stage
    import clk_presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [EXP_W-1:0] expo,
    output logic             last,
    output logic             half
);
    logic [BIN_W-1:0] cnt;

    assign last = (cnt == bin_limit(expo));
    assign half = cnt[expo];

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // R5
    half_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(half) |-> $past(step));

endmodule

// File: rtl/clk_presc.sv
module clk_presc
    import clk_presc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_load,
    input  logic [31:0] cfg_word,
    output logic        tick,
    output logic        half_clk
);
    presc_cfg_t active;
    logic       lin_wrap;
    logic       bin_last;
    logic       bin_half;

    presc_cfg_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .word     (cfg_word),
        .boundary (tick),
        .active   (active)
    );

    presc_lin_stage u_lin (
        .clk  (clk),
        .rst  (rst),
        .lim  (active.lin),
        .wrap (lin_wrap)
    );

    presc_bin_stage u_bin (
        .clk  (clk),
        .rst  (rst),
        .step (lin_wrap),
        .expo (active.expo),
        .last (bin_last),
        .half (bin_half)
    );

    assign tick     = lin_wrap & bin_last & ~rst;
    assign half_clk = bin_half & ~rst;

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5
    half_restart_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !half_clk);

endmodule

// File: tb/test_clk_presc.sv
module test_clk_presc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        tick;
    logic        half_clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int    period;
        string req;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    clk_presc i_clk_presc (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .tick     (tick),
        .half_clk (half_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input int n, input int m, input string req);
        exp_t e;
        e.period = (1 << (n + 1)) * (m + 1);
        e.req    = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick);
    endtask

    // called at a negedge where tick is high: load lands on the boundary edge
    task automatic boundary_load(input logic [31:0] w, input int n, input int m,
                                 input int cnt, input string req);
        cfg_word = w;
        cfg_load = 1'b1;
        for (int i = 0; i < cnt; i++) push(n, m, req);
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (cnt) wait_tick();
    endtask

    // monitor: measures each period and its high half, compares against the queue
    int cyc  = 0;
    int hcnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            cyc  = 0;
            hcnt = 0;
        end else begin
            cyc++;
            if (half_clk) hcnt++;
            if (tick) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected tick", cyc, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.period, e.req, cyc, e.period);
                    check(hcnt == e.period / 2, "R5 half-high count", hcnt, e.period / 2);
                end
                cyc  = 0;
                hcnt = 0;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        // R1: outputs idle during reset
        repeat (5) begin
            @(negedge clk);
            check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
            check(half_clk == 1'b0, "R1 half_clk in reset", int'(half_clk), 0);
        end
        @(posedge clk);
        #1 rst = 1'b0;

        // R1 default ratio 40, R2 repeating period
        push(1, 9, "R1 default period");
        push(1, 9, "R2 steady period");
        wait_tick();
        wait_tick();

        // R7 boundary load takes effect at once; R9 minimal ratio
        boundary_load(32'h0000_0000, 0, 0, 3, "R7 R9 ratio 2 after boundary load");
        // R3 field placement
        boundary_load(32'h0000_3018, 3, 24, 1, "R3 fields N=3 M=24");
        // R4 upper bits ignored
        boundary_load(32'hABCD_1005, 1, 5, 2, "R4 upper bits ignored");

        // R6 mid-period load: running period keeps old length
        push(1, 5, "R6 running period unchanged");
        repeat (3) @(negedge clk);
        cfg_word = 32'h0000_2003;
        cfg_load = 1'b1;
        push(2, 3, "R6 new setting next period");
        push(2, 3, "R6 new setting kept");
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (3) wait_tick();

        // R8 last of several loads wins
        push(2, 3, "R8 running period unchanged");
        repeat (2) @(negedge clk);
        cfg_word = 32'h0000_0007;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_word = 32'h0000_1002;
        push(1, 2, "R8 last load wins");
        push(1, 2, "R8 last load kept");
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (3) wait_tick();

        // R10 full-range settings
        boundary_load(32'h0000_607C, 6, 124, 1, "R10 N=6 M=124");
        boundary_load(32'h0000_418F, 4, 399, 1, "R10 N=4 M=399");
        boundary_load(32'h0000_0A21, 0, 2593, 1, "R10 N=0 M=2593");

        @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected periods seen", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule